// File: doc/BRIEF.md
# Loopback Pattern Test Sequencer

This block exercises a parallel 32-bit link between two devices. Software first fills a source memory with a test pattern through a byte-wide host port. A start command then makes the sequencer read the source memory once per clock and drive each word onto the outgoing link. Playback wraps around the memory and keeps going until a stop command. The link returns the data after some round-trip delay. After a programmable number of cycles the sequencer begins to store the returning words into a capture memory. Software can then read the capture memory back and compare it with the pattern it wrote.

The sequencer has four named states. `S_IDLE` gives the host port both memories. `S_LATENCY` plays back while it counts down the latency. `S_LOOP` plays back and captures one word per cycle. `S_HOLD` plays back after the capture memory is full. The transitions are named as follows:
- `start`: `S_IDLE` to `S_LATENCY`, or straight to `S_LOOP` when the latency is zero.
- `latency_expired`: `S_LATENCY` to `S_LOOP`.
- `capture_full`: `S_LOOP` to `S_HOLD`.
- `stop`: any running state to `S_IDLE`.

Both memories are single-ported. The port of each memory is multiplexed between the host and the sequencer according to whether a sequence is running.

Top module: `lbk_pattern_seq`

## Requirements
- R1: After reset `seq_running`, `capture_done` and `host_refused` are 0.
- R2: While idle, a host access with `host_en`=1 reaches one memory. `host_ram_sel` picks it (0 = source, 1 = capture). `host_addr[10:2]` gives the word and `host_addr[1:0]` the byte lane (lane 0 = bits 7:0). A write stores `host_wdata` into that lane. A read returns the lane on `host_rdata` in the cycle after the request. `host_rdata` then holds while idle until the next read.
- R3: A `start_cmd` seen while idle sets `seq_running` at that edge. If E0 is the edge that accepts the start, `link_tx` carries source word k after edge E(k+1).
- R4: Playback wraps from word 511 back to word 0. It keeps repeating until stopped.
- R5: With latency L (`lat_cfg`), capture word j stores the value of `link_rx` during cycle L+j, where cycle 0 follows E0. With L=0, capture starts in the same cycle as the first source read.
- R6: Exactly 512 words are captured. `capture_done` rises at edge E(L+512). No capture write happens after that.
- R7: A `stop_cmd` while running clears `seq_running` at that edge. No word is captured in the stop cycle. An incomplete capture leaves `capture_done` at 0.
- R8: While running, a host access raises `host_refused` and changes no memory content.
- R9: `start_cmd` while running does not restart playback. `stop_cmd` while idle has no effect.
- R10: `capture_done` stays set, even across a stop, until the next accepted start clears it.
- R11: Playback continues correctly after the capture is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for host and test |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | Start a sequence (taken when idle) |
| stop_cmd | input | 1 | End the running sequence |
| lat_cfg | input | 16 | Cycles from first source read to first capture write |
| link_tx | output | 32 | Pattern word driven onto the link |
| link_rx | input | 32 | Word returning from the link |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = byte write, 0 = byte read |
| host_ram_sel | input | 1 | 0 = source memory, 1 = capture memory |
| host_addr | input | 11 | Word index in bits 10:2, byte lane in bits 1:0 |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle after the request |
| host_refused | output | 1 | Host access refused because a sequence runs |
| seq_running | output | 1 | A sequence is in progress |
| capture_done | output | 1 | All capture words have been written |

## Verification
The assertions check the following on every cycle:
- The start and stop edges of `seq_running`.
- That `capture_done` is cleared by a new start and is otherwise sticky.
- That `capture_done` rises only after exactly 512 capture writes since the start.
- That the host read byte stays still while the host leaves the port alone.

Only the bench scenarios can show that the data is right. This covers the word order on `link_tx` across the wrap and the latency alignment for zero and non-zero settings. It also covers that no word is overwritten once capture is full: the bench inverts the return path after `capture_done` and then reads the capture memory back. Finally, the bench shows that refused host writes leave both memories unchanged.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LATENCY = 2'd1,
        S_LOOP    = 2'd2,
        S_HOLD    = 2'd3
    } seq_state_t;

endpackage

// File: rtl/lbk_ram.sv
module lbk_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = W / 8,
    localparam int LW    = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          acc_en,
    input  logic          word_we,
    input  logic          byte_we,
    input  logic [LW-1:0] lane,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [7:0]    bdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // One access per cycle: a word write, a byte write or a word read.
    always_ff @(posedge clk) begin
        if (acc_en) begin
            if (word_we) begin
                mem[addr] <= wdata;
            end else if (byte_we) begin
                mem[addr][{lane, 3'b000} +: 8] <= bdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
    import lbk_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int LAT_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic             busy,
    output logic             done,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    seq_state_t       state, state_nx;
    logic [AW-1:0]    rd_ptr, wr_ptr;
    logic [LAT_W-1:0] lat_cnt;
    logic             take_start;

    assign take_start = (state == S_IDLE) && start_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start_cmd)
                    state_nx = (lat_cfg == '0) ? S_LOOP : S_LATENCY;
            end
            S_LATENCY: begin
                if (stop_cmd)           state_nx = S_IDLE;
                else if (lat_cnt == '0) state_nx = S_LOOP;
            end
            S_LOOP: begin
                if (stop_cmd)            state_nx = S_IDLE;
                else if (wr_ptr == LAST) state_nx = S_HOLD;
            end
            S_HOLD: begin
                if (stop_cmd) state_nx = S_IDLE;
            end
        endcase
    end

    always_comb begin
        busy    = (state != S_IDLE);
        rd_en   = busy;
        rd_addr = rd_ptr;
        wr_en   = (state == S_LOOP) && !stop_cmd;
        wr_addr = wr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            lat_cnt <= '0;
            done    <= 1'b0;
        end else if (take_start) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            lat_cnt <= lat_cfg - LAT_W'(1);
            done    <= 1'b0;
        end else begin
            if (busy)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            if (state == S_LATENCY && lat_cnt != '0)
                lat_cnt <= lat_cnt - LAT_W'(1);
            if (wr_en) begin
                if (wr_ptr == LAST) done   <= 1'b1;
                else                wr_ptr <= wr_ptr + AW'(1);
            end
        end
    end

endmodule

// File: rtl/lbk_pattern_seq.sv
module lbk_pattern_seq #(
    parameter int W     = 32,
    parameter int DEPTH = 512,
    parameter int LAT_W = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(W / 8),
    localparam int HA_W = AW + LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic [LAT_W-1:0] lat_cfg,
    output logic [W-1:0]     link_tx,
    input  logic [W-1:0]     link_rx,
    input  logic             host_en,
    input  logic             host_we,
    input  logic             host_ram_sel,
    input  logic [HA_W-1:0]  host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             host_refused,
    output logic             seq_running,
    output logic             capture_done
);

    logic          busy, src_rd, cap_wr;
    logic [AW-1:0] src_addr, cap_addr;
    logic          host_ok;
    logic [AW-1:0] host_word;
    logic [LW-1:0] host_lane, lane_q;
    logic          rsel_q;
    logic [W-1:0]  sel_word;

    logic          acc_en  [2];
    logic          word_we [2];
    logic [AW-1:0] ram_addr[2];
    logic [W-1:0]  ram_q   [2];

    lbk_ctrl #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .lat_cfg   (lat_cfg),
        .busy      (busy),
        .done      (capture_done),
        .rd_en     (src_rd),
        .rd_addr   (src_addr),
        .wr_en     (cap_wr),
        .wr_addr   (cap_addr)
    );

    assign host_word    = host_addr[HA_W-1:LW];
    assign host_lane    = host_addr[LW-1:0];
    assign host_ok      = host_en && !busy;
    assign host_refused = host_en && busy;
    assign seq_running  = busy;

    // Port 0 is the source memory, port 1 the capture memory.
    for (genvar g = 0; g < 2; g++) begin : g_ram
        always_comb begin
            if (busy) begin
                acc_en[g]   = (g == 0) ? src_rd : cap_wr;
                ram_addr[g] = (g == 0) ? src_addr : cap_addr;
                word_we[g]  = (g == 1) && cap_wr;
            end else begin
                acc_en[g]   = host_ok && (host_ram_sel == (g == 1));
                ram_addr[g] = host_word;
                word_we[g]  = 1'b0;
            end
        end

        lbk_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
            .clk     (clk),
            .acc_en  (acc_en[g]),
            .word_we (word_we[g]),
            .byte_we (!busy && host_we),
            .lane    (host_lane),
            .addr    (ram_addr[g]),
            .wdata   (link_rx),
            .bdata   (host_wdata),
            .rdata   (ram_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q <= 1'b0;
            lane_q <= '0;
        end else if (host_ok && !host_we) begin
            rsel_q <= host_ram_sel;
            lane_q <= host_lane;
        end
    end

    assign sel_word   = rsel_q ? ram_q[1] : ram_q[0];
    assign host_rdata = sel_word[{lane_q, 3'b000} +: 8];
    assign link_tx    = ram_q[0];

endmodule

// File: rtl/lbk_pattern_seq_chk.sv
module lbk_pattern_seq_chk #(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_cmd,
    input logic       stop_cmd,
    input logic       host_en,
    input logic       host_we,
    input logic [7:0] host_rdata,
    input logic       seq_running,
    input logic       capture_done,
    input logic       cap_wr
);

    logic [CW-1:0] wr_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                          wr_cnt <= '0;
        else if (start_cmd && !seq_running)  wr_cnt <= '0;
        else if (cap_wr)                     wr_cnt <= wr_cnt + CW'(1);
    end

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_running && start_cmd) |=> seq_running);

    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_running && stop_cmd) |=> !seq_running);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_done && !(start_cmd && !seq_running)) |=> capture_done);

    p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_running && start_cmd) |=> !capture_done);

    p_done_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(capture_done) |-> (wr_cnt == CW'(DEPTH)));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_running && !(host_en && !host_we)) |=> $stable(host_rdata));

endmodule

bind lbk_pattern_seq lbk_pattern_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_cmd    (start_cmd),
    .stop_cmd     (stop_cmd),
    .host_en      (host_en),
    .host_we      (host_we),
    .host_rdata   (host_rdata),
    .seq_running  (seq_running),
    .capture_done (capture_done),
    .cap_wr       (cap_wr)
);

// File: tb/sim_lbk_pattern_seq.sv
`timescale 1ns/1ps
module sim_lbk_pattern_seq;

    localparam int DEPTH = 512;
    localparam logic [31:0] MARK = 32'hDEADBEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_cmd = 1'b0, stop_cmd = 1'b0;
    logic [15:0] lat_cfg = '0;
    logic [31:0] link_tx, link_rx;
    logic        host_en = 1'b0, host_we = 1'b0, host_ram_sel = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_refused, seq_running, capture_done;

    logic [31:0] p1, p2, flip = '0;
    int          n_chk = 0, n_bad = 0, cyc = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    // Return path: two register stages, optional inversion.
    always_ff @(posedge clk) begin
        p1 <= link_tx;
        p2 <= p1;
    end
    assign link_rx = p2 ^ flip;

    lbk_pattern_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .lat_cfg(lat_cfg), .link_tx(link_tx), .link_rx(link_rx),
        .host_en(host_en), .host_we(host_we), .host_ram_sel(host_ram_sel),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_refused(host_refused), .seq_running(seq_running),
        .capture_done(capture_done)
    );

    // {sel, word[8:0], lane[1:0], byte[7:0]}
    localparam logic [19:0] VEC [8] = '{
        {1'b0, 9'd0,   2'd0, 8'h11}, {1'b0, 9'd0,   2'd3, 8'h44},
        {1'b0, 9'd511, 2'd1, 8'hA7}, {1'b1, 9'd0,   2'd2, 8'h3C},
        {1'b1, 9'd255, 2'd0, 8'hC3}, {1'b1, 9'd511, 2'd3, 8'h5E},
        {1'b0, 9'd300, 2'd2, 8'h81}, {1'b1, 9'd9,   2'd1, 8'hF0}
    };

    function automatic logic [31:0] pat(input int k);
        return 32'h9E3779B9 * 32'(k + 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); cyc++;
    endtask

    task automatic host_wr(input logic sel, input int word, input int lane, input logic [7:0] b);
        host_en = 1; host_we = 1; host_ram_sel = sel;
        host_addr = 11'(word * 4 + lane); host_wdata = b;
        @(posedge clk); @(negedge clk);
        host_en = 0; host_we = 0;
    endtask

    task automatic host_rd(input logic sel, input int word, input int lane, output logic [7:0] b);
        host_en = 1; host_we = 0; host_ram_sel = sel;
        host_addr = 11'(word * 4 + lane);
        @(posedge clk); @(negedge clk);
        host_en = 0;
        b = host_rdata;
    endtask

    task automatic wr_word(input logic sel, input int word, input logic [31:0] v);
        for (int l = 0; l < 4; l++) host_wr(sel, word, l, v[8*l +: 8]);
    endtask

    task automatic rd_word(input logic sel, input int word, output logic [31:0] v);
        logic [7:0] b;
        for (int l = 0; l < 4; l++) begin
            host_rd(sel, word, l, b);
            v[8*l +: 8] = b;
        end
    endtask

    task automatic do_start(input int lat);
        lat_cfg = 16'(lat); flip = '0; start_cmd = 1;
        @(posedge clk); @(negedge clk);
        start_cmd = 0; cyc = 0;
    endtask

    task automatic do_stop();
        stop_cmd = 1; step(); stop_cmd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] w;

        repeat (3) @(negedge clk);
        check("R1 running", 32'(seq_running), 0);
        check("R1 done", 32'(capture_done), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 refused", 32'(host_refused), 0);

        // R2: table of host byte writes, then read-back
        for (int i = 0; i < 8; i++)
            host_wr(VEC[i][19], int'(VEC[i][18:10]), int'(VEC[i][9:8]), VEC[i][7:0]);
        for (int i = 0; i < 8; i++) begin
            host_rd(VEC[i][19], int'(VEC[i][18:10]), int'(VEC[i][9:8]), b);
            check("R2 host byte", 32'(b), 32'(VEC[i][7:0]));
        end
        step(); step();
        check("R2 rdata hold", 32'(host_rdata), 32'(VEC[7][7:0]));

        // Load the pattern and markers.
        for (int k = 0; k < DEPTH; k++) wr_word(0, k, pat(k));
        wr_word(1, 9, MARK);
        wr_word(1, 10, MARK);

        // Run A: latency 3, restart attempt, refused access, early stop.
        do_start(3);
        check("R3 running", 32'(seq_running), 1);
        step(); check("R3 word0", link_tx, pat(0));
        step(); check("R3 word1", link_tx, pat(1));
        while (cyc < 5) step();
        start_cmd = 1; step(); start_cmd = 0;
        check("R9 no restart", link_tx, pat(5));
        step(); check("R9 no restart", link_tx, pat(6));
        host_en = 1; host_we = 1; host_ram_sel = 0; host_addr = '0; host_wdata = 8'hFF;
        #0.1;
        check("R8 refused", 32'(host_refused), 1);
        step(); host_en = 0; host_we = 0;
        while (cyc < 13) step();
        do_stop();
        check("R7 stopped", 32'(seq_running), 0);
        check("R7 not done", 32'(capture_done), 0);
        rd_word(1, 0, w);  check("R5 lat3 word0", w, pat(0));
        rd_word(1, 9, w);  check("R5 lat3 word9", w, pat(9));
        rd_word(1, 10, w); check("R7 stop cycle not captured", w, MARK);
        rd_word(0, 0, w);  check("R8 write ignored", w, pat(0));
        do_stop();
        check("R9 stop idle", 32'(seq_running), 0);

        // Run B: latency 5, full capture, wrap, inverted return after done.
        do_start(5);
        while (cyc < 1200) begin
            step();
            if (cyc == 512)  check("R4 word511", link_tx, pat(511));
            if (cyc == 513)  check("R4 wrap", link_tx, pat(0));
            if (cyc == 516)  check("R6 not yet done", 32'(capture_done), 0);
            if (cyc == 517) begin
                check("R6 done", 32'(capture_done), 1);
                flip = '1;
            end
            if (cyc == 1100) check("R11 after done", link_tx, pat(1099 % DEPTH));
        end
        do_stop();
        check("R10 sticky", 32'(capture_done), 1);
        rd_word(1, 0, w);   check("R6 no overwrite", w, pat(2));
        rd_word(1, 200, w); check("R5 lat5", w, pat(202));
        rd_word(1, 511, w); check("R6 last word", w, pat(1));

        // Run C: latency 0.
        do_start(0);
        step(); check("R10 cleared", 32'(capture_done), 0);
        while (cyc < 511) step();
        check("R6 lat0 not yet", 32'(capture_done), 0);
        step(); check("R6 lat0 done", 32'(capture_done), 1);
        while (cyc < 520) step();
        do_stop();
        rd_word(1, 3, w);  check("R5 lat0 word3", w, pat(0));
        rd_word(1, 50, w); check("R5 lat0 word50", w, pat(47));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule